// File: doc/BRIEF.md
# Speculative Load Alias Tracker

This block keeps a small table of loads that a scheduler has hoisted above earlier stores. Each time such an early load issues, its destination register, byte address and access size are recorded. Every later store is compared against all live records. Any record whose byte range intersects the store's range is marked stale, because the value already loaded no longer matches memory.

Before the hoisted value is consumed, the pipeline asks the table about the destination register. A valid answer lets the speculated value stand. A stale answer tells the pipeline to reissue the load, or to branch to a recovery sequence that reloads and re-runs the dependent work. A single broadcast input drops every record at once, for example on a context switch. The block performs no memory access itself.

The check answer is combinational within the query cycle. Table updates land on the next rising clock edge.

Top module: `spec_load_tracker`

## Requirements
- R1: After reset, no register has a record, so every query reports stale (`chk_redo`=1, `chk_ok`=0).
- R2: A record inserted in one cycle and queried in a later cycle, with no intervening overlapping store, flush or eviction, reports valid. While `chk_vld`=1, exactly one of `chk_ok` and `chk_redo` is high. While `chk_vld`=0, both are 0.
- R3: A store covers 2^size bytes starting at its address, with size codes 0,1,2,3 meaning 1,2,4,8 bytes. The same rule applies to inserted loads. A store whose range intersects a record's range, even by one byte, makes that record stale. A store that only abuts the range leaves the record valid.
- R4: A store and a query in the same cycle interact store-first. If the store overlaps the queried record, the query already reports stale.
- R5: Inserting a register that already has a live record replaces the address and size of that record. Stores to the old range then no longer affect the register.
- R6: With all 16 entries live, inserting a new register evicts the least recently inserted record. A later query for the evicted register reports stale.
- R7: `flush_all` clears every record, including one inserted in the same cycle. A query in the flush cycle reports stale.
- R8: An insert with an overlapping store in the same cycle is recorded stale. A query in the insert cycle sees the table as it was before the insert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_all | input | 1 | Drop every record |
| ins_vld | input | 1 | Hoisted load issued this cycle |
| ins_reg | input | REG_W (7) | Destination register of the hoisted load |
| ins_addr | input | ADDR_W (32) | Byte address of the hoisted load |
| ins_size | input | SIZE_W (2) | Size code of the hoisted load |
| st_vld | input | 1 | Store snoop valid |
| st_addr | input | ADDR_W (32) | Byte address of the store |
| st_size | input | SIZE_W (2) | Size code of the store |
| chk_vld | input | 1 | Validity query this cycle |
| chk_reg | input | REG_W (7) | Register being queried |
| chk_ok | output | 1 | Speculated value still valid |
| chk_redo | output | 1 | Value stale: reload or recover |

## Verification
The temporal properties assume that an access range never wraps past the top of the address space. Under that assumption, byte-range intersection computed with one extra address bit is exact. The stimulus keeps addresses inside a small low window, far below the top, so ranges never wrap. The window is small enough that overlaps and exact abutments occur often. The properties also assume that at most one insert, one store and one query arrive per cycle, which the single-issue ports enforce.

// File: rtl/spec_trk_pkg.sv
package spec_trk_pkg;
   // access size code: bytes = 2**code
   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } acc_size_e;

   localparam int unsigned DEF_ENTRIES = 16;
   localparam int unsigned DEF_REG_W   = 7;
   localparam int unsigned DEF_ADDR_W  = 32;
   localparam int unsigned DEF_SIZE_W  = 2;
endpackage

// File: rtl/spec_trk_overlap.sv
module spec_trk_overlap #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SIZE_W = 2
) (
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [SIZE_W-1:0] a_size,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [SIZE_W-1:0] b_size,
   output logic              hit
);
   localparam int unsigned EXT_W = ADDR_W + 1;

   logic [EXT_W-1:0] a_lo, a_hi, b_lo, b_hi;

   always_comb begin
      a_lo = {1'b0, a_addr};
      b_lo = {1'b0, b_addr};
      a_hi = a_lo + (EXT_W'(1) << a_size);
      b_hi = b_lo + (EXT_W'(1) << b_size);
      hit  = (a_lo < b_hi) && (b_lo < a_hi);
   end
endmodule

// File: rtl/spec_trk_slot.sv
module spec_trk_slot #(
   parameter int unsigned REG_W  = 7,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SIZE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic              wr_live,
   input  logic [REG_W-1:0]  wr_reg,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [SIZE_W-1:0] wr_size,
   input  logic              st_vld,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [SIZE_W-1:0] st_size,
   input  logic [REG_W-1:0]  q_reg,
   output logic              live,
   output logic              q_hit,
   output logic              ins_hit
);
   logic              live_q;
   logic [REG_W-1:0]  reg_q;
   logic [ADDR_W-1:0] addr_q;
   logic [SIZE_W-1:0] size_q;
   logic              st_ov;
   logic              kill;

   spec_trk_overlap #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ov (
      .a_addr (addr_q),
      .a_size (size_q),
      .b_addr (st_addr),
      .b_size (st_size),
      .hit    (st_ov)
   );

   assign kill    = st_vld && st_ov;
   assign live    = live_q;
   assign q_hit   = live_q && !kill && (reg_q == q_reg);
   assign ins_hit = live_q && (reg_q == wr_reg);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q <= 1'b0;
         reg_q  <= '0;
         addr_q <= '0;
         size_q <= '0;
      end else begin
         if (flush)      live_q <= 1'b0;
         else if (wr_en) live_q <= wr_live;
         else if (kill)  live_q <= 1'b0;
         if (wr_en) begin
            reg_q  <= wr_reg;
            addr_q <= wr_addr;
            size_q <= wr_size;
         end
      end
   end
endmodule

// File: rtl/spec_trk_age.sv
module spec_trk_age #(
   parameter int unsigned ENTRIES = 16,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [ENTRIES-1:0] live,
   output logic [IDX_W-1:0]   oldest
);
   // older_q[i][j] = entry i was written before entry j
   logic [ENTRIES-1:0] older_q [ENTRIES];
   logic [ENTRIES-1:0] cand;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_row
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            older_q[i] <= '0;
         end else if (wr_en) begin
            for (int j = 0; j < ENTRIES; j++) begin
               if (IDX_W'(i) == wr_idx)      older_q[i][j] <= 1'b0;
               else if (IDX_W'(j) == wr_idx) older_q[i][j] <= 1'b1;
            end
         end
      end

      always_comb begin
         cand[i] = live[i];
         for (int j = 0; j < ENTRIES; j++) begin
            if (j != i && live[j] && !older_q[i][j]) cand[i] = 1'b0;
         end
      end
   end

   always_comb begin
      oldest = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (cand[i]) oldest = IDX_W'(i);
      end
   end
endmodule

// File: rtl/spec_load_tracker.sv
module spec_load_tracker
   import spec_trk_pkg::*;
#(
   parameter int unsigned ENTRIES = DEF_ENTRIES,
   parameter int unsigned REG_W   = DEF_REG_W,
   parameter int unsigned ADDR_W  = DEF_ADDR_W,
   parameter int unsigned SIZE_W  = DEF_SIZE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_all,
   input  logic              ins_vld,
   input  logic [REG_W-1:0]  ins_reg,
   input  logic [ADDR_W-1:0] ins_addr,
   input  logic [SIZE_W-1:0] ins_size,
   input  logic              st_vld,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [SIZE_W-1:0] st_size,
   input  logic              chk_vld,
   input  logic [REG_W-1:0]  chk_reg,
   output logic              chk_ok,
   output logic              chk_redo
);
   localparam int unsigned IDX_W    = $clog2(ENTRIES);
   localparam int unsigned MAX_SHFT = (1 << SIZE_W) - 1;

   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("ENTRIES must be a power of two, at least 2");
   end
   if (MAX_SHFT >= ADDR_W) begin : g_bad_size
      $error("largest access must be smaller than the address space");
   end
   if (REG_W < 1) begin : g_bad_reg
      $error("REG_W must be positive");
   end

   logic [ENTRIES-1:0] live, q_hit, ins_hit, wr_en;
   logic [IDX_W-1:0]   hit_idx, free_idx, oldest_idx, victim;
   logic               any_hit, any_free, ins_st_ov, wr_live;

   spec_trk_overlap #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ins_ov (
      .a_addr (ins_addr),
      .a_size (ins_size),
      .b_addr (st_addr),
      .b_size (st_size),
      .hit    (ins_st_ov)
   );
   assign wr_live = !(st_vld && ins_st_ov);

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      assign wr_en[i] = ins_vld && (victim == IDX_W'(i));
      spec_trk_slot #(.REG_W(REG_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .flush   (flush_all),
         .wr_en   (wr_en[i]),
         .wr_live (wr_live),
         .wr_reg  (ins_reg),
         .wr_addr (ins_addr),
         .wr_size (ins_size),
         .st_vld  (st_vld),
         .st_addr (st_addr),
         .st_size (st_size),
         .q_reg   (chk_reg),
         .live    (live[i]),
         .q_hit   (q_hit[i]),
         .ins_hit (ins_hit[i])
      );
   end

   spec_trk_age #(.ENTRIES(ENTRIES)) u_age (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (ins_vld),
      .wr_idx (victim),
      .live   (live),
      .oldest (oldest_idx)
   );

   // victim: same register, else lowest free slot, else oldest record
   always_comb begin
      hit_idx  = '0;
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (ins_hit[i]) hit_idx  = IDX_W'(i);
         if (!live[i])   free_idx = IDX_W'(i);
      end
      any_hit  = |ins_hit;
      any_free = ~&live;
      if (any_hit)       victim = hit_idx;
      else if (any_free) victim = free_idx;
      else               victim = oldest_idx;
   end

   assign chk_ok   = chk_vld && !flush_all && (|q_hit);
   assign chk_redo = chk_vld && !chk_ok;
endmodule

// File: rtl/spec_trk_chk.sv
module spec_trk_chk #(
   parameter int unsigned REG_W  = 7,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SIZE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush_all,
   input logic              ins_vld,
   input logic [REG_W-1:0]  ins_reg,
   input logic [ADDR_W-1:0] ins_addr,
   input logic [SIZE_W-1:0] ins_size,
   input logic              st_vld,
   input logic [ADDR_W-1:0] st_addr,
   input logic [SIZE_W-1:0] st_size,
   input logic              chk_vld,
   input logic [REG_W-1:0]  chk_reg,
   input logic              chk_ok,
   input logic              chk_redo
);
   logic              seen;
   logic              p_ins, p_flush, p_ins_dead;
   logic [REG_W-1:0]  p_reg;
   logic [ADDR_W-1:0] p_addr;
   logic [SIZE_W-1:0] p_size;
   logic [ADDR_W:0]   i_end, s_end, p_end;
   logic              now_ins_st, st_hits_prev;

   always_comb begin
      i_end = {1'b0, ins_addr} + ((ADDR_W+1)'(1) << ins_size);
      s_end = {1'b0, st_addr}  + ((ADDR_W+1)'(1) << st_size);
      p_end = {1'b0, p_addr}   + ((ADDR_W+1)'(1) << p_size);
      now_ins_st   = st_vld && ({1'b0, st_addr} < i_end) && ({1'b0, ins_addr} < s_end);
      st_hits_prev = st_vld && ({1'b0, st_addr} < p_end) && ({1'b0, p_addr} < s_end);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen <= 1'b0; p_ins <= 1'b0; p_flush <= 1'b0; p_ins_dead <= 1'b0;
         p_reg <= '0; p_addr <= '0; p_size <= '0;
      end else begin
         seen <= 1'b1; p_ins <= ins_vld; p_flush <= flush_all; p_ins_dead <= now_ins_st;
         p_reg <= ins_reg; p_addr <= ins_addr; p_size <= ins_size;
      end
   end

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_vld |-> (!chk_ok && !chk_redo));

   // R7
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && p_flush) |-> !chk_ok);

   // R2
   insert_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && p_ins && !p_flush && !p_ins_dead && chk_vld && chk_reg == p_reg
       && !st_vld && !flush_all) |-> chk_ok);

   // R8
   insert_born_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && p_ins && p_ins_dead && chk_vld && chk_reg == p_reg) |-> chk_redo);

   // R4
   store_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && p_ins && chk_vld && chk_reg == p_reg && st_hits_prev) |-> chk_redo);
endmodule

bind spec_load_tracker spec_trk_chk #(.REG_W(REG_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_chk (.*);

// File: tb/spec_load_tracker_test.sv
`timescale 1ns/1ps
module spec_load_tracker_test;
   localparam int N = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush_all = 0, ins_vld = 0, st_vld = 0, chk_vld = 0;
   logic [6:0]  ins_reg = '0, chk_reg = '0;
   logic [31:0] ins_addr = '0, st_addr = '0;
   logic [1:0]  ins_size = '0, st_size = '0;
   logic chk_ok, chk_redo;

   int total = 0, bad = 0;
   bit done = 0;

   bit          m_v [N];
   logic [6:0]  m_r [N];
   logic [31:0] m_a [N];
   logic [1:0]  m_s [N];
   int          m_t [N];
   int          stamp = 0;

   always #4 clk = ~clk;

   spec_load_tracker uut (
      .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
      .ins_vld(ins_vld), .ins_reg(ins_reg), .ins_addr(ins_addr), .ins_size(ins_size),
      .st_vld(st_vld), .st_addr(st_addr), .st_size(st_size),
      .chk_vld(chk_vld), .chk_reg(chk_reg), .chk_ok(chk_ok), .chk_redo(chk_redo)
   );

   function automatic bit ovl(logic [31:0] a, logic [1:0] as, logic [31:0] b, logic [1:0] bs);
      longint alo = a, blo = b;
      longint ahi = alo + (64'd1 << as), bhi = blo + (64'd1 << bs);
      return (alo < bhi) && (blo < ahi);
   endfunction

   function automatic bit exp_ok();
      if (!chk_vld || flush_all) return 0;
      for (int i = 0; i < N; i++)
         if (m_v[i] && m_r[i] == chk_reg && !(st_vld && ovl(m_a[i], m_s[i], st_addr, st_size)))
            return 1;
      return 0;
   endfunction

   task automatic model_update();
      int v = -1;
      if (ins_vld) begin
         for (int i = 0; i < N; i++) if (m_v[i] && m_r[i] == ins_reg) v = i;
         if (v < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) v = i;
         if (v < 0) begin
            v = 0;
            for (int i = 1; i < N; i++) if (m_t[i] < m_t[v]) v = i;
         end
      end
      for (int i = 0; i < N; i++)
         if (st_vld && m_v[i] && ovl(m_a[i], m_s[i], st_addr, st_size)) m_v[i] = 0;
      if (ins_vld) begin
         m_v[v] = !(st_vld && ovl(ins_addr, ins_size, st_addr, st_size));
         m_r[v] = ins_reg; m_a[v] = ins_addr; m_s[v] = ins_size;
         m_t[v] = stamp; stamp++;
      end
      if (flush_all) for (int i = 0; i < N; i++) m_v[i] = 0;
   endtask

   task automatic clr();
      flush_all = 0; ins_vld = 0; st_vld = 0; chk_vld = 0;
   endtask

   // inputs were set after a falling edge; check, update model, move to next falling edge
   task automatic step(string tag);
      bit e;
      #1;
      e = exp_ok();
      total++;
      if (chk_ok !== e || chk_redo !== (chk_vld && !e)) begin
         bad++;
         $display("FAIL %s: ok/redo actual=%b/%b expected=%b/%b", tag, chk_ok, chk_redo, e, chk_vld && !e);
      end
      model_update();
      @(negedge clk);
      clr();
   endtask

   task automatic do_ins(logic [6:0] r, logic [31:0] a, logic [1:0] s);
      ins_vld = 1; ins_reg = r; ins_addr = a; ins_size = s;
   endtask
   task automatic do_st(logic [31:0] a, logic [1:0] s);
      st_vld = 1; st_addr = a; st_size = s;
   endtask
   task automatic do_chk(logic [6:0] r);
      chk_vld = 1; chk_reg = r;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5eed_0711);
      for (int i = 0; i < N; i++) begin m_v[i] = 0; m_r[i] = '0; m_a[i] = '0; m_s[i] = '0; m_t[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      do_chk(7'd5); step("R1");
      do_chk(7'd0); step("R1");
      // R2 idle query outputs
      step("R2");
      // R2 insert then query
      do_ins(7'd1, 32'h100, 2'd3); step("R2");
      do_chk(7'd1); step("R2");
      // R8 query in insert cycle sees old table
      do_ins(7'd2, 32'h180, 2'd2); do_chk(7'd2); step("R8");
      do_chk(7'd2); step("R8");
      // R3 abutting store leaves record
      do_st(32'h108, 2'd0); step("R3");
      do_chk(7'd1); step("R3");
      do_st(32'hFC, 2'd2); step("R3");
      do_chk(7'd1); step("R3");
      // R3 one-byte overlap at top edge
      do_st(32'h107, 2'd0); step("R3");
      do_chk(7'd1); step("R3");
      // R3 partial overlap from below
      do_ins(7'd1, 32'h100, 2'd3); step("R3");
      do_st(32'hFF, 2'd1); step("R3");
      do_chk(7'd1); step("R3");
      // R4 store and query same cycle
      do_ins(7'd3, 32'h200, 2'd3); step("R4");
      do_st(32'h204, 2'd2); do_chk(7'd3); step("R4");
      do_chk(7'd3); step("R4");
      // R5 reinsertion replaces address
      do_ins(7'd4, 32'h300, 2'd3); step("R5");
      do_ins(7'd4, 32'h400, 2'd3); step("R5");
      do_st(32'h300, 2'd3); step("R5");
      do_chk(7'd4); step("R5");
      do_st(32'h400, 2'd0); step("R5");
      do_chk(7'd4); step("R5");
      // R6 eviction of oldest when full
      flush_all = 1; step("R7");
      for (int k = 0; k < 16; k++) begin do_ins(7'(10 + k), 32'h1000 + 32'(k * 16), 2'd3); step("R6"); end
      do_ins(7'd26, 32'h2000, 2'd3); step("R6");
      do_chk(7'd10); step("R6");
      do_chk(7'd11); step("R6");
      do_chk(7'd26); step("R6");
      do_ins(7'd27, 32'h2100, 2'd3); step("R6");
      do_chk(7'd11); step("R6");
      do_chk(7'd12); step("R6");
      // R7 flush with query and with insert
      do_ins(7'd30, 32'h3000, 2'd3); step("R7");
      flush_all = 1; do_chk(7'd30); step("R7");
      do_chk(7'd30); step("R7");
      do_ins(7'd31, 32'h3100, 2'd3); flush_all = 1; step("R7");
      do_chk(7'd31); step("R7");
      // R8 insert with overlapping store same cycle
      do_ins(7'd40, 32'h500, 2'd3); do_st(32'h504, 2'd0); step("R8");
      do_chk(7'd40); step("R8");
      // random mix, R3 ranges and R6 replacement under load
      for (int c = 0; c < 4000; c++) begin
         if ($urandom_range(99) < 45) do_ins(7'($urandom_range(23)), 32'($urandom_range(127)), 2'($urandom_range(3)));
         if ($urandom_range(99) < 25) do_st(32'($urandom_range(127)), 2'($urandom_range(3)));
         if ($urandom_range(99) < 60) do_chk(7'($urandom_range(23)));
         if ($urandom_range(299) == 0) flush_all = 1;
         step("R3");
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule